// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front-End

This block is the software-facing half of a serial peripheral controller. It sits on a plain 32-bit memory-mapped bus with a strobe, write flag, byte address, write data and combinational read data. It keeps the configuration registers that a separate serial engine consumes. These are the enable, clock setup, transmit and receive word formats and frame setup. It also keeps two eight-entry FIFOs. Software writes words for transmission and reads received words through one shared data offset.

On the engine side, the block offers the head of the transmit FIFO with a valid/ready handshake. It accepts received words as single-cycle pulses and watches a "shifting" input to decide when the link is busy. It keeps three sticky event flags: transmit complete, receive complete and receive overrun. Software clears each flag by writing one to it, and it can unmask each flag onto a single interrupt line. Register offsets are word aligned. The word index is taken from address bits 5:2, with offsets 0x00 control, 0x04 clock, 0x08 transmit format, 0x0C receive format, 0x10 frame, 0x14 status, 0x18 interrupt enable, 0x1C interrupt clear and 0x20 FIFO control. Offset 0x24 is the data port.

Top module: `spi_fe_top`

## Requirements
- R1: After reset, every register reads 0 except status, which reads 0x20. The interrupt output and `eng_tx_valid` are low.
- R2: Bit 0 of control (0x00) is the enable. While it is 0, `eng_tx_valid` stays low even when the transmit FIFO holds data. While it is 1, `eng_tx_valid` shows that the transmit FIFO is non-empty, and `eng_tx_data` is its oldest word.
- R3: A bus write to 0x24 pushes the write data into the transmit FIFO. A bus read of 0x24 returns and removes the oldest receive FIFO word. Both FIFOs are first-in first-out. A read of an empty receive FIFO returns 0.
- R4: Each FIFO holds 8 words. A push into a full FIFO is discarded, unless a pop happens in the same cycle.
- R5: Status (0x14) bit 7 is busy (transmit FIFO non-empty or `eng_shifting` high). Bit 5 is transmit FIFO not full, and bit 0 is receive FIFO not empty. All other status bits read 0.
- R6: In FIFO control (0x20), writing 1 to bit 12 empties the transmit FIFO and writing 1 to bit 4 empties the receive FIFO, both at that write's clock edge. Those two bits always read 0. Bits 11:8 (transmit threshold) and 3:0 (receive threshold) are stored and read back.
- R7: A word that arrives from the engine while the receive FIFO is full and not being read in the same cycle is dropped, and the overrun flag (bit 0) is set. If a bus read of 0x24 and an engine word land in the same cycle on a full FIFO, the word is accepted and no overrun is raised.
- R8: The receive-complete flag (bit 3) is set when an accepted engine word brings the receive FIFO count to at least the receive threshold. A threshold of 0 acts as 1.
- R9: The transmit-complete flag (bit 4) is set one clock edge after busy falls from 1 to 0.
- R10: Reading 0x1C returns the flags at bits 4, 3 and 0. Writing 1 to any of those bits clears that flag. If a set and a clear hit one flag in the same cycle, the set wins.
- R11: `irq` is high when any flag is set and its bit in interrupt enable (0x18, same positions 4, 3, 0) is 1. Only those three enable bits are stored.
- R12: Only these fields are stored and driven out: clock setup bits 14:12 and 7:0, transmit format bits 13:0, receive format bits 7:0, and frame setup bits 15:14. All other bits of these registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| cfg_clk | output | 32 | Stored clock setup fields |
| cfg_txfmt | output | 32 | Stored transmit word format |
| cfg_rxfmt | output | 32 | Stored receive word format |
| cfg_frame | output | 32 | Stored frame setup fields |
| eng_tx_valid | output | 1 | Transmit word available |
| eng_tx_ready | input | 1 | Engine takes the offered word |
| eng_tx_data | output | DATA_W | Oldest transmit FIFO word |
| eng_shifting | input | 1 | Engine is still shifting a word |
| eng_rx_valid | input | 1 | Received word pulse |
| eng_rx_data | input | DATA_W | Received word |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of events can meet in one cycle. A software read of the data port can coincide with an engine delivery into a full receive FIFO. An engine event that sets a flag can coincide with a software write that clears the same flag. The bench provokes both by driving the bus strobe and `eng_rx_valid` on the same clock edge, with the FIFO filled to eight entries. For the first pair it expects the oldest word back, no overrun flag, and the delivered word last in the drained order. For the second pair it expects the overrun flag still set when read back. A seeded random mix of pushes, engine takes, deliveries and reads is checked against queue models for data order, status bits and the final overrun flag.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    // word index = byte address [5:2]
    typedef enum logic [3:0] {
        IDX_CTRL  = 4'd0,
        IDX_CLK   = 4'd1,
        IDX_TXF   = 4'd2,
        IDX_RXF   = 4'd3,
        IDX_FRAME = 4'd4,
        IDX_STAT  = 4'd5,
        IDX_IE    = 4'd6,
        IDX_IC    = 4'd7,
        IDX_FC    = 4'd8,
        IDX_DATA  = 4'd9
    } reg_idx_e;

    localparam logic [31:0] CLK_MASK   = 32'h0000_70FF;
    localparam logic [31:0] TXF_MASK   = 32'h0000_3FFF;
    localparam logic [31:0] RXF_MASK   = 32'h0000_00FF;
    localparam logic [31:0] FRAME_MASK = 32'h0000_C000;

    localparam int BIT_OVR  = 0;
    localparam int BIT_RXC  = 3;
    localparam int BIT_TXC  = 4;
    localparam int BIT_RXFL = 4;
    localparam int BIT_TXFL = 12;
    localparam int BIT_RXNE = 0;
    localparam int BIT_TXNF = 5;
    localparam int BIT_BUSY = 7;

    localparam int NUM_FLAGS = 3;
    // flag vector index order
    localparam int FL_OVR = 0;
    localparam int FL_RXC = 1;
    localparam int FL_TXC = 2;

    typedef struct packed {
        logic        en;
        logic [31:0] clk;
        logic [31:0] txf;
        logic [31:0] rxf;
        logic [31:0] frame;
        logic [NUM_FLAGS-1:0] ie;
        logic [3:0]  tx_thr;
        logic [3:0]  rx_thr;
        logic        busy;
    } regs_t;

endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign dout  = mem[st_q.rd];

    assign pop_ok  = pop && !empty && !flush;
    assign push_ok = push && (!full || pop_ok) && !flush;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = ptr_inc(st_q.wr);
            if (pop_ok)  st_d.rd = ptr_inc(st_q.rd);
            if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= din;
    end

endmodule

// File: rtl/spi_fe_irq.sv
module spi_fe_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] enable,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            flags_d[i] = set[i] | (flags_q[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & enable);

endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
    import spi_fe_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       cfg_clk,
    output logic [31:0]       cfg_txfmt,
    output logic [31:0]       cfg_rxfmt,
    output logic [31:0]       cfg_frame,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_shifting,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              irq
);

    regs_t r_d, r_q;

    logic [3:0] idx;
    logic       wr_hit, rd_hit;
    logic       tx_flush, rx_flush;
    logic       tx_push, tx_pop, rx_pop;
    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic       tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic [DATA_W-1:0] rx_head;
    logic       busy;
    logic [NUM_FLAGS-1:0] fl_set, fl_clr, flags;
    int         rx_new_cnt, rx_thr_eff;

    assign idx    = bus_addr[5:2];
    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    assign tx_flush = wr_hit && (idx == IDX_FC) && bus_wdata[BIT_TXFL];
    assign rx_flush = wr_hit && (idx == IDX_FC) && bus_wdata[BIT_RXFL];
    assign tx_push  = wr_hit && (idx == IDX_DATA);
    assign rx_pop   = rd_hit && (idx == IDX_DATA);
    assign tx_pop   = eng_tx_valid && eng_tx_ready;

    spi_fe_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) tx_fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .push    (tx_push),
        .din     (bus_wdata[DATA_W-1:0]),
        .pop     (tx_pop),
        .dout    (eng_tx_data),
        .count   (tx_count),
        .full    (tx_full),
        .empty   (tx_empty),
        .push_ok (tx_push_ok),
        .pop_ok  (tx_pop_ok)
    );

    spi_fe_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) rx_fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .push    (eng_rx_valid),
        .din     (eng_rx_data),
        .pop     (rx_pop),
        .dout    (rx_head),
        .count   (rx_count),
        .full    (rx_full),
        .empty   (rx_empty),
        .push_ok (rx_push_ok),
        .pop_ok  (rx_pop_ok)
    );

    assign eng_tx_valid = r_q.en && !tx_empty;
    assign busy         = !tx_empty || eng_shifting;

    // event detection
    assign rx_new_cnt = int'(rx_count) + 1 - (rx_pop_ok ? 1 : 0);
    assign rx_thr_eff = (r_q.rx_thr == '0) ? 1 : int'(r_q.rx_thr);

    always_comb begin
        fl_set = '0;
        fl_set[FL_OVR] = eng_rx_valid && rx_full && !rx_pop_ok && !rx_flush;
        fl_set[FL_RXC] = rx_push_ok && (rx_new_cnt >= rx_thr_eff);
        fl_set[FL_TXC] = r_q.busy && !busy;
        fl_clr = '0;
        if (wr_hit && (idx == IDX_IC)) begin
            fl_clr[FL_OVR] = bus_wdata[BIT_OVR];
            fl_clr[FL_RXC] = bus_wdata[BIT_RXC];
            fl_clr[FL_TXC] = bus_wdata[BIT_TXC];
        end
    end

    spi_fe_irq #(.N(NUM_FLAGS)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (fl_set),
        .clr    (fl_clr),
        .enable (r_q.ie),
        .flags  (flags),
        .irq    (irq)
    );

    // register next state
    always_comb begin
        r_d      = r_q;
        r_d.busy = busy;
        if (wr_hit) begin
            unique case (idx)
                IDX_CTRL:  r_d.en    = bus_wdata[0];
                IDX_CLK:   r_d.clk   = bus_wdata & CLK_MASK;
                IDX_TXF:   r_d.txf   = bus_wdata & TXF_MASK;
                IDX_RXF:   r_d.rxf   = bus_wdata & RXF_MASK;
                IDX_FRAME: r_d.frame = bus_wdata & FRAME_MASK;
                IDX_IE: begin
                    r_d.ie[FL_OVR] = bus_wdata[BIT_OVR];
                    r_d.ie[FL_RXC] = bus_wdata[BIT_RXC];
                    r_d.ie[FL_TXC] = bus_wdata[BIT_TXC];
                end
                IDX_FC: begin
                    r_d.tx_thr = bus_wdata[11:8];
                    r_d.rx_thr = bus_wdata[3:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (idx)
                IDX_CTRL:  bus_rdata[0] = r_q.en;
                IDX_CLK:   bus_rdata    = r_q.clk;
                IDX_TXF:   bus_rdata    = r_q.txf;
                IDX_RXF:   bus_rdata    = r_q.rxf;
                IDX_FRAME: bus_rdata    = r_q.frame;
                IDX_STAT: begin
                    bus_rdata[BIT_BUSY] = busy;
                    bus_rdata[BIT_TXNF] = !tx_full;
                    bus_rdata[BIT_RXNE] = !rx_empty;
                end
                IDX_IE: begin
                    bus_rdata[BIT_OVR] = r_q.ie[FL_OVR];
                    bus_rdata[BIT_RXC] = r_q.ie[FL_RXC];
                    bus_rdata[BIT_TXC] = r_q.ie[FL_TXC];
                end
                IDX_IC: begin
                    bus_rdata[BIT_OVR] = flags[FL_OVR];
                    bus_rdata[BIT_RXC] = flags[FL_RXC];
                    bus_rdata[BIT_TXC] = flags[FL_TXC];
                end
                IDX_FC: begin
                    bus_rdata[11:8] = r_q.tx_thr;
                    bus_rdata[3:0]  = r_q.rx_thr;
                end
                IDX_DATA: begin
                    if (!rx_empty) bus_rdata[DATA_W-1:0] = rx_head;
                end
                default: ;
            endcase
        end
    end

    assign cfg_clk   = r_q.clk;
    assign cfg_txfmt = r_q.txf;
    assign cfg_rxfmt = r_q.rxf;
    assign cfg_frame = r_q.frame;

endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
    parameter int CNT_W = 4,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_bit,
    input logic             eng_tx_valid,
    input logic             eng_rx_valid,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic             rx_full,
    input logic             rx_pop_ok,
    input logic [2:0]       flags,
    input logic [2:0]       ie_bits,
    input logic             irq,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       idx,
    input logic [31:0]      bus_rdata
);

    p_txvalid_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid |-> en_bit)
        else $error("p_txvalid_en_r2");

    p_tx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_count) <= DEPTH)
        else $error("p_tx_bound_r4");

    p_rx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_count) <= DEPTH)
        else $error("p_rx_bound_r4");

    p_tx_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_count == '0))
        else $error("p_tx_flush_r6");

    p_rx_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_count == '0))
        else $error("p_rx_flush_r6");

    p_fc_reads0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && idx == 4'd8) |-> (bus_rdata[12] == 1'b0 && bus_rdata[4] == 1'b0))
        else $error("p_fc_reads0_r6");

    p_ovr_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && rx_full && !rx_pop_ok && !rx_flush) |=> flags[0])
        else $error("p_ovr_sets_r7");

    p_ovr_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && rx_full && !rx_pop_ok && !rx_flush) |=> $stable(rx_count))
        else $error("p_ovr_keeps_count_r7");

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_bits == 3'b000) |-> !irq)
        else $error("p_irq_masked_r11");

endmodule

bind spi_fe_top spi_fe_chk #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_bit       (r_q.en),
    .eng_tx_valid (eng_tx_valid),
    .eng_rx_valid (eng_rx_valid),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .tx_flush     (tx_flush),
    .rx_flush     (rx_flush),
    .rx_full      (rx_full),
    .rx_pop_ok    (rx_pop_ok),
    .flags        (flags),
    .ie_bits      (r_q.ie),
    .irq          (irq),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .idx          (idx),
    .bus_rdata    (bus_rdata)
);

// File: tb/spi_fe_top_tb_top.sv
`timescale 1ns/1ps
module spi_fe_top_tb_top;

    localparam logic [5:0] A_CTRL = 6'h00, A_CLK = 6'h04, A_TXF = 6'h08, A_RXF = 6'h0C,
                           A_FRAME = 6'h10, A_STAT = 6'h14, A_IE = 6'h18, A_IC = 6'h1C,
                           A_FC = 6'h20, A_DATA = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] cfg_clk, cfg_txfmt, cfg_rxfmt, cfg_frame;
    logic        eng_tx_valid, eng_tx_ready = 1'b0;
    logic [31:0] eng_tx_data;
    logic        eng_shifting = 1'b0, eng_rx_valid = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        irq;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_fe_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_clk(cfg_clk), .cfg_txfmt(cfg_txfmt),
        .cfg_rxfmt(cfg_rxfmt), .cfg_frame(cfg_frame), .eng_tx_valid(eng_tx_valid),
        .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data), .eng_shifting(eng_shifting),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic deliver(input logic [31:0] d);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic take(output logic v, output logic [31:0] d);
        @(negedge clk);
        #1 v = eng_tx_valid; d = eng_tx_data;
        eng_tx_ready = 1'b1;
        @(negedge clk);
        eng_tx_ready = 1'b0;
    endtask

    function automatic logic [31:0] stat_exp(input int txn, input int rxn, input bit shift);
        logic [31:0] s = '0;
        s[7] = (txn != 0) || shift;
        s[5] = (txn < 8);
        s[0] = (rxn != 0);
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        v;
        logic [31:0] txq[$];
        logic [31:0] rxq[$];
        bit          ovr_exp;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bread(A_STAT, rd); chk("R1 status", rd, 32'h20);
        bread(A_CTRL, rd); chk("R1 ctrl", rd, 0);
        bread(A_IC, rd);   chk("R1 flags", rd, 0);
        bread(A_FC, rd);   chk("R1 fifo ctrl", rd, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 tx_valid", {31'b0, eng_tx_valid}, 0);

        // R12 masked config fields
        bwrite(A_CLK, 32'hFFFF_FFFF);   bread(A_CLK, rd);   chk("R12 clk", rd, 32'h70FF);
        chk("R12 cfg_clk port", cfg_clk, 32'h70FF);
        bwrite(A_TXF, 32'hFFFF_FFFF);   bread(A_TXF, rd);   chk("R12 txfmt", rd, 32'h3FFF);
        bwrite(A_RXF, 32'hFFFF_FFFF);   bread(A_RXF, rd);   chk("R12 rxfmt", rd, 32'hFF);
        bwrite(A_FRAME, 32'hFFFF_FFFF); bread(A_FRAME, rd); chk("R12 frame", rd, 32'hC000);
        chk("R12 cfg_frame port", cfg_frame, 32'hC000);

        // R2 enable gating
        bwrite(A_DATA, 32'h1111_0001);
        @(negedge clk); #1 chk("R2 disabled no valid", {31'b0, eng_tx_valid}, 0);
        bwrite(A_CTRL, 32'h1);
        @(negedge clk); #1 chk("R2 enabled valid", {31'b0, eng_tx_valid}, 1);
        take(v, rd); chk("R2 tx data", rd, 32'h1111_0001);
        @(negedge clk); #1 chk("R2 empty no valid", {31'b0, eng_tx_valid}, 0);

        // R3/R4 fill TX with 9 writes, 9th dropped
        for (int i = 0; i < 9; i++) begin
            bwrite(A_DATA, 32'hA000_0000 + i);
            if (i == 7) begin
                bread(A_STAT, rd); chk("R4 tx full status", rd, stat_exp(8, 0, 0));
            end
        end
        for (int i = 0; i < 8; i++) begin
            take(v, rd); chk("R3 tx order", rd, 32'hA000_0000 + i);
        end
        @(negedge clk); #1 chk("R4 ninth dropped", {31'b0, eng_tx_valid}, 0);

        // R6 flushes
        bwrite(A_CTRL, 32'h0);
        bwrite(A_DATA, 32'h5); bwrite(A_DATA, 32'h6);
        bwrite(A_FC, 32'h0000_1302);
        bread(A_STAT, rd); chk("R6 tx flushed", rd, stat_exp(0, 0, 0));
        bread(A_FC, rd);   chk("R6 fc readback", rd, 32'h0302);
        deliver(32'h7); deliver(32'h8);
        bread(A_STAT, rd); chk("R5 rx not empty", rd, stat_exp(0, 2, 0));
        bwrite(A_FC, 32'h0000_0312);
        bread(A_STAT, rd); chk("R6 rx flushed", rd, stat_exp(0, 0, 0));
        bread(A_DATA, rd); chk("R3 empty read 0", rd, 0);

        // R7 overrun
        bwrite(A_IC, 32'h19);
        for (int i = 0; i < 8; i++) deliver(32'hB000_0000 + i);
        bread(A_IC, rd); chk("R7 no ovr at 8", rd & 32'h1, 0);
        deliver(32'hDEAD);
        bread(A_IC, rd); chk("R7 ovr set", rd & 32'h1, 1);
        for (int i = 0; i < 8; i++) begin
            bread(A_DATA, rd); chk("R7 rx order", rd, 32'hB000_0000 + i);
        end
        bread(A_DATA, rd); chk("R7 dropped word absent", rd, 0);

        // R7 simultaneous read + delivery on full FIFO
        bwrite(A_IC, 32'h1);
        for (int i = 0; i < 8; i++) deliver(32'hC000_0000 + i);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_DATA;
        eng_rx_valid = 1'b1; eng_rx_data = 32'hBEEF;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; eng_rx_valid = 1'b0;
        chk("R7 simul read oldest", rd, 32'hC000_0000);
        bread(A_IC, rd); chk("R7 simul no ovr", rd & 32'h1, 0);
        for (int i = 1; i < 8; i++) begin
            bread(A_DATA, rd); chk("R7 simul order", rd, 32'hC000_0000 + i);
        end
        bread(A_DATA, rd); chk("R7 simul word kept", rd, 32'hBEEF);

        // R10 set beats clear
        for (int i = 0; i < 8; i++) deliver(i);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_IC; bus_wdata = 32'h1;
        eng_rx_valid = 1'b1; eng_rx_data = 32'h99;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; eng_rx_valid = 1'b0;
        bread(A_IC, rd); chk("R10 set wins", rd & 32'h1, 1);
        bwrite(A_IC, 32'h19);
        bread(A_IC, rd); chk("R10 w1c all", rd, 0);

        // R8 receive threshold
        bwrite(A_FC, 32'h0000_0013);
        bwrite(A_IC, 32'h19);
        deliver(1); deliver(2);
        bread(A_IC, rd); chk("R8 below thr", rd & 32'h8, 0);
        deliver(3);
        bread(A_IC, rd); chk("R8 at thr", rd & 32'h8, 32'h8);

        // R9 transmit complete, R5 busy from shifting
        bwrite(A_FC, 32'h0000_0013);
        bwrite(A_IC, 32'h19);
        bwrite(A_CTRL, 32'h1);
        bwrite(A_DATA, 32'h42);
        @(negedge clk);
        #1 rd = eng_tx_data;
        eng_tx_ready = 1'b1; eng_shifting = 1'b1;
        @(negedge clk);
        eng_tx_ready = 1'b0;
        chk("R9 data taken", rd, 32'h42);
        bread(A_STAT, rd); chk("R5 busy while shifting", rd, stat_exp(0, 0, 1));
        bread(A_IC, rd);   chk("R9 not yet", rd & 32'h10, 0);
        @(negedge clk); eng_shifting = 1'b0;
        bread(A_IC, rd);   chk("R9 tx complete", rd & 32'h10, 32'h10);
        bread(A_STAT, rd); chk("R5 idle", rd, stat_exp(0, 0, 0));

        // R11 irq masking
        bwrite(A_IC, 32'h19);
        for (int i = 0; i < 9; i++) deliver(i);
        bwrite(A_IE, 32'h0);
        @(negedge clk); #1 chk("R11 masked", {31'b0, irq}, 0);
        bwrite(A_IE, 32'h1);
        @(negedge clk); #1 chk("R11 ovr irq", {31'b0, irq}, 1);
        bread(A_IE, rd); chk("R11 ie readback", rd, 32'h1);
        bwrite(A_IC, 32'h1);
        @(negedge clk); #1 chk("R11 rxc not enabled", {31'b0, irq}, 0);
        bwrite(A_IE, 32'h8);
        @(negedge clk); #1 chk("R11 rxc irq", {31'b0, irq}, 1);
        bwrite(A_IE, 32'h0);

        // random mix (R3 R4 R5 R7)
        bwrite(A_FC, 32'h0000_1010);
        bwrite(A_IC, 32'h19);
        ovr_exp = 1'b0;
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom_range(0, 3));
            logic [31:0] d = $urandom;
            case (op)
                0: begin
                    bwrite(A_DATA, d);
                    if (txq.size() < 8) txq.push_back(d);
                end
                1: begin
                    take(v, rd);
                    chk("R2 rand valid", {31'b0, v}, {31'b0, txq.size() != 0});
                    if (txq.size() != 0) begin
                        chk("R3 rand tx data", rd, txq[0]);
                        void'(txq.pop_front());
                    end
                end
                2: begin
                    deliver(d);
                    if (rxq.size() < 8) rxq.push_back(d);
                    else ovr_exp = 1'b1;
                end
                default: begin
                    bread(A_DATA, rd);
                    if (rxq.size() != 0) begin
                        chk("R3 rand rx data", rd, rxq[0]);
                        void'(rxq.pop_front());
                    end else begin
                        chk("R3 rand empty read", rd, 0);
                    end
                end
            endcase
            bread(A_STAT, rd);
            chk("R5 rand status", rd, stat_exp(txq.size(), rxq.size(), 0));
        end
        bread(A_IC, rd); chk("R7 rand ovr", rd & 32'h1, {31'b0, ovr_exp});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule